// File: doc/BRIEF.md
# Serial Port Status and Edge Counter

This block keeps the status side of a small serial port that can run as a two-wire bus or as a three-wire link. It holds a clock-edge counter and four event flags in one host-visible byte. It raises interrupt and wake-up requests from those flags. In two-wire operation it also produces the two requests that hold the clock line low while the host services an event.

The host reads the whole byte at any time. It writes the counter field directly. It clears any flag by writing a one to that flag's bit. The clock and data line levels arrive already synchronized to `clk`. The block keeps the previous levels of both lines, so it can detect edges, start conditions and stop conditions.

Register layout, from most significant bit down:
- bit 7: start flag
- bit 6: overflow flag
- bit 5: stop flag
- bit 4: collision flag
- bits 3:0: the counter

Top module: `sio_status`

## Requirements
- R1: After reset, every flag and the counter read as zero, and the previous clock and data line levels are taken as high. The layout is: bit 7 start, bit 6 overflow, bit 5 stop, bit 4 collision, bits 3:0 counter.
- R2: The counter increments by one in the cycle after a counting event. The event depends on `csel`: 0 means a `sw_strobe` pulse; 1 means a `timer_tick` pulse; 2 or 3 means any change of `scl_in`, so both edges count. Inputs that the current `csel` does not select have no effect on the counter.
- R3: An increment from 15 wraps the counter to 0 and sets the overflow flag.
- R4: When `mode` is 2 or 3 (two-wire), the start flag is set when `sda_in` falls while `scl_in` is high in both the previous and the current cycle.
- R5: In two-wire mode, the stop flag is set when `sda_in` rises while `scl_in` is high in both cycles.
- R6: In two-wire mode, the collision flag is set on a rising `scl_in` when `drv_bit` is 1 and `sda_in` reads 0.
- R7: When `mode` is 0 or 1, the start flag is set on any change of `scl_in` while `csel` is 2 or 3 and `sw_strobe` is 0.
- R8: A flag clears only when a write carries a one in its bit. Writing zero leaves it unchanged. If a set event and a clearing write fall in the same cycle, the flag stays set.
- R9: `hold_start` is high while the mode is two-wire and the start flag is set. `hold_ovf` is high while `mode` is 3 and the overflow flag is set. Each hold drops once its flag is cleared.
- R10: `start_irq` equals start flag AND `start_ie`. `ovf_irq` equals overflow flag AND `ovf_ie`.
- R11: `wake_any` follows `start_irq`. `wake_idle` is high when either interrupt request is high.
- R12: A host write to the counter field takes priority over a counting event in the same cycle, and such a write never sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | CNT_W+4 | Host write data |
| rd_data | output | CNT_W+4 | Register contents |
| mode | input | 2 | Wire mode: 0 off, 1 three-wire, 2 two-wire, 3 two-wire with overflow hold |
| csel | input | 2 | Counter clock select |
| sw_strobe | input | 1 | Software count strobe |
| timer_tick | input | 1 | Timer count pulse |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| drv_bit | input | 1 | Bit currently driven onto the data line |
| start_ie | input | 1 | Start interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| start_irq | output | 1 | Start interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| hold_start | output | 1 | Hold clock low after a start |
| hold_ovf | output | 1 | Hold clock low after an overflow |
| wake_any | output | 1 | Wake-up from any sleep state |
| wake_idle | output | 1 | Wake-up from idle |

## Verification
The assertions assume that `scl_in` and `sda_in` are already synchronous to `clk`, and that the host writes at most once per cycle. They also assume that `mode` and `csel` change only between cycles. The bench drives every input on the falling clock edge and changes one line level at a time, which keeps the stimulus inside those assumptions. It still covers a start event and a clearing write in the same cycle, and a counter write together with a strobe.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_3W     = 2'd1,
        MODE_2W     = 2'd2,
        MODE_2W_OVH = 2'd3
    } wire_mode_e;

    typedef enum logic [1:0] {
        CS_SOFT  = 2'd0,
        CS_TICK  = 2'd1,
        CS_EXT_A = 2'd2,
        CS_EXT_B = 2'd3
    } clk_sel_e;

    typedef struct packed {
        logic start_f;
        logic ovf_f;
        logic stop_f;
        logic col_f;
    } flags_t;
endpackage

// File: rtl/sio_line_mon.sv
module sio_line_mon
    import sio_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] csel,
    input  logic       sw_strobe,
    input  logic       timer_tick,
    input  logic       scl,
    input  logic       sda,
    input  logic       drv_bit,
    output logic       start_ev,
    output logic       stop_ev,
    output logic       col_ev,
    output logic       cnt_ev
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    lines_t lines_d, lines_q;
    logic   two_wire, ext_clk, scl_edge;

    always_comb begin
        lines_d.scl = scl;
        lines_d.sda = sda;
        two_wire    = mode[1];
        ext_clk     = csel[1];
        scl_edge    = scl ^ lines_q.scl;

        if (two_wire) begin
            start_ev = lines_q.sda & ~sda & lines_q.scl & scl;
        end else begin
            start_ev = ext_clk & ~sw_strobe & scl_edge;
        end
        stop_ev = two_wire & ~lines_q.sda & sda & lines_q.scl & scl;
        col_ev  = two_wire & ~lines_q.scl & scl & drv_bit & ~sda;

        unique case (clk_sel_e'(csel))
            CS_SOFT: cnt_ev = sw_strobe;
            CS_TICK: cnt_ev = timer_tick;
            default: cnt_ev = scl_edge;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lines_q <= lines_d;
        end
    end
endmodule

// File: rtl/sio_edge_cnt.sv
module sio_edge_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             cnt_ev,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        wrap_ev = 1'b0;
        if (wr_en) begin
            cnt_d = wr_val;
        end else if (cnt_ev) begin
            cnt_d   = cnt_q + 1'b1;
            wrap_ev = (cnt_q == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sio_status.sv
module sio_status
    import sio_status_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W+3:0] wr_data,
    output logic [CNT_W+3:0] rd_data,
    input  logic [1:0]       mode,
    input  logic [1:0]       csel,
    input  logic             sw_strobe,
    input  logic             timer_tick,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             drv_bit,
    input  logic             start_ie,
    input  logic             ovf_ie,
    output logic             start_irq,
    output logic             ovf_irq,
    output logic             hold_start,
    output logic             hold_ovf,
    output logic             wake_any,
    output logic             wake_idle
);
    localparam int REG_W = CNT_W + 4;

    logic             start_ev, stop_ev, col_ev, cnt_ev, wrap_ev;
    logic [CNT_W-1:0] cnt;
    flags_t           flags_d, flags_q, clr;

    sio_line_mon i_line_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .csel       (csel),
        .sw_strobe  (sw_strobe),
        .timer_tick (timer_tick),
        .scl        (scl_in),
        .sda        (sda_in),
        .drv_bit    (drv_bit),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .col_ev     (col_ev),
        .cnt_ev     (cnt_ev)
    );

    sio_edge_cnt #(.CNT_W(CNT_W)) i_edge_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_val  (wr_data[CNT_W-1:0]),
        .cnt_ev  (cnt_ev),
        .cnt     (cnt),
        .wrap_ev (wrap_ev)
    );

    always_comb begin
        clr = wr_en ? flags_t'(wr_data[REG_W-1:CNT_W]) : '0;
        // A set event in the same cycle outranks the clearing write.
        flags_d.start_f = start_ev | (flags_q.start_f & ~clr.start_f);
        flags_d.ovf_f   = wrap_ev  | (flags_q.ovf_f   & ~clr.ovf_f);
        flags_d.stop_f  = stop_ev  | (flags_q.stop_f  & ~clr.stop_f);
        flags_d.col_f   = col_ev   | (flags_q.col_f   & ~clr.col_f);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign rd_data    = {flags_q, cnt};
    assign start_irq  = flags_q.start_f & start_ie;
    assign ovf_irq    = flags_q.ovf_f & ovf_ie;
    assign hold_start = mode[1] & flags_q.start_f;
    assign hold_ovf   = (wire_mode_e'(mode) == MODE_2W_OVH) & flags_q.ovf_f;
    assign wake_any   = start_irq;
    assign wake_idle  = start_irq | ovf_irq;
endmodule

// File: rtl/sio_status_chk.sv
module sio_status_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CNT_W+3:0] wr_data,
    input logic [CNT_W+3:0] rd_data,
    input logic [1:0]       mode,
    input logic             start_ie,
    input logic             start_irq,
    input logic             ovf_irq,
    input logic             hold_start,
    input logic             hold_ovf,
    input logic             wake_idle
);
    localparam int TOP = CNT_W + 3;

    assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_data[CNT_W-1:0]) == {CNT_W{1'b1}} && rd_data[CNT_W-1:0] == '0
         && !$past(wr_en)) |-> rd_data[TOP-1]);

    assert_start_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[TOP] && !(wr_en && wr_data[TOP])) |=> rd_data[TOP]);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[TOP-1] && !(wr_en && wr_data[TOP-1])) |=> rd_data[TOP-1]);

    assert_hold_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ovf |-> (mode == 2'd3 && rd_data[TOP-1]));

    assert_hold_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_start |-> (mode[1] && rd_data[TOP]));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |-> (start_ie && rd_data[TOP]));

    assert_wake_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_irq || ovf_irq) |-> wake_idle);
endmodule

bind sio_status sio_status_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .mode       (mode),
    .start_ie   (start_ie),
    .start_irq  (start_irq),
    .ovf_irq    (ovf_irq),
    .hold_start (hold_start),
    .hold_ovf   (hold_ovf),
    .wake_idle  (wake_idle)
);

// File: tb/test_sio_status.sv
`timescale 1ns/1ps
module test_sio_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] mode = '0, csel = '0;
    logic sw_strobe = 0, timer_tick = 0, scl_in = 1, sda_in = 1, drv_bit = 0;
    logic start_ie = 0, ovf_ie = 0;
    logic start_irq, ovf_irq, hold_start, hold_ovf, wake_any, wake_idle;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference state
    int m_cnt = 0;
    bit m_st = 0, m_ov = 0, m_sp = 0, m_col = 0, p_scl = 1, p_sda = 1;

    always #2.5 clk = ~clk;

    sio_status i_sio_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mode(mode), .csel(csel), .sw_strobe(sw_strobe), .timer_tick(timer_tick),
        .scl_in(scl_in), .sda_in(sda_in), .drv_bit(drv_bit),
        .start_ie(start_ie), .ovf_ie(ovf_ie), .start_irq(start_irq), .ovf_irq(ovf_irq),
        .hold_start(hold_start), .hold_ovf(hold_ovf), .wake_any(wake_any), .wake_idle(wake_idle)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit two, ext, edge_s, ev_st, ev_sp, ev_col, inc, ev_ov;
        two = mode[1]; ext = csel[1]; edge_s = (scl_in != p_scl);
        ev_st = two ? (p_sda && !sda_in && p_scl && scl_in) : (ext && !sw_strobe && edge_s);
        ev_sp = two && !p_sda && sda_in && p_scl && scl_in;
        ev_col = two && !p_scl && scl_in && drv_bit && !sda_in;
        inc = (csel == 0) ? sw_strobe : (csel == 1) ? timer_tick : edge_s;
        ev_ov = 0;
        if (wr_en) m_cnt = wr_data[3:0];
        else if (inc) begin ev_ov = (m_cnt == 15); m_cnt = (m_cnt + 1) % 16; end
        m_st  = ev_st  || (m_st  && !(wr_en && wr_data[7]));
        m_ov  = ev_ov  || (m_ov  && !(wr_en && wr_data[6]));
        m_sp  = ev_sp  || (m_sp  && !(wr_en && wr_data[5]));
        m_col = ev_col || (m_col && !(wr_en && wr_data[4]));
        p_scl = scl_in; p_sda = sda_in;
    endtask

    task automatic compare_all();
        bit si, oi;
        si = m_st && start_ie; oi = m_ov && ovf_ie;
        chk("R4 start flag", rd_data[7], m_st);
        chk("R3 overflow flag", rd_data[6], m_ov);
        chk("R5 stop flag", rd_data[5], m_sp);
        chk("R6 collision flag", rd_data[4], m_col);
        chk("R2 counter", rd_data[3:0], m_cnt);
        chk("R10 start_irq", start_irq, si);
        chk("R10 ovf_irq", ovf_irq, oi);
        chk("R9 hold_start", hold_start, mode[1] && m_st);
        chk("R9 hold_ovf", hold_ovf, (mode == 3) && m_ov);
        chk("R11 wake_any", wake_any, si);
        chk("R11 wake_idle", wake_idle, si || oi);
    endtask

    // inputs are set after a falling edge; one clock then compare at the next falling edge
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en = 0; sw_strobe = 0; timer_tick = 0;
    endtask

    task automatic host_wr(input logic [7:0] v);
        wr_en = 1; wr_data = v; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset value", rd_data, 8'h00);
        compare_all();

        // R2 software strobe counting, tick ignored when not selected
        csel = 0;
        repeat (3) begin sw_strobe = 1; step(); end
        timer_tick = 1; step();
        chk("R2 soft count", rd_data[3:0], 3);

        // R3 wrap with overflow hold
        mode = 3; ovf_ie = 1;
        host_wr(8'h0E);
        sw_strobe = 1; step();
        sw_strobe = 1; step();
        chk("R3 wrap to zero", rd_data[3:0], 0);
        chk("R3 overflow set", rd_data[6], 1);
        chk("R9 hold_ovf on", hold_ovf, 1);
        host_wr(8'h00);
        chk("R8 write zero keeps", rd_data[6], 1);
        host_wr(8'h40);
        chk("R8 write one clears", rd_data[6], 0);
        chk("R9 hold_ovf released", hold_ovf, 0);

        // R12 write beats strobe
        wr_en = 1; wr_data = 8'h05; sw_strobe = 1; step();
        chk("R12 write priority", rd_data[3:0], 5);
        host_wr(8'h0F);
        wr_en = 1; wr_data = 8'h03; sw_strobe = 1; step();
        chk("R12 no overflow on write", rd_data[6], 0);

        // R4 start in two-wire mode
        mode = 2; start_ie = 1; scl_in = 1; sda_in = 1; step();
        sda_in = 0; step();
        chk("R4 start detect", rd_data[7], 1);
        chk("R9 hold_start", hold_start, 1);
        chk("R11 wake_any", wake_any, 1);
        host_wr(8'h80);
        chk("R9 hold_start released", hold_start, 0);

        // R8 set beats clear: new start with clearing write in same cycle
        sda_in = 1; step();
        sda_in = 0; wr_en = 1; wr_data = 8'h80; step();
        chk("R8 set wins over clear", rd_data[7], 1);
        host_wr(8'hF0);

        // R5 stop
        sda_in = 1; step();
        chk("R5 stop detect", rd_data[5], 1);
        host_wr(8'h20);

        // R6 collision: scl low then rise with drv_bit=1, sda=0
        scl_in = 0; step();
        sda_in = 0; drv_bit = 1; step();
        scl_in = 1; step();
        chk("R6 collision", rd_data[4], 1);
        drv_bit = 0; host_wr(8'hF0);

        // R7 three-wire external clock edges, both edges counted
        mode = 1; csel = 2; host_wr(8'h00);
        scl_in = 0; step();
        chk("R7 edge sets start", rd_data[7], 1);
        scl_in = 1; step();
        chk("R2 both edges counted", rd_data[3:0], 2);
        host_wr(8'h80);
        sw_strobe = 1; scl_in = 0; step();
        chk("R7 strobe blocks start", rd_data[7], 0);

        // R2 timer tick select in output-disabled mode
        mode = 0; csel = 1; host_wr(8'h00);
        repeat (4) begin timer_tick = 1; step(); end
        sw_strobe = 1; step();
        chk("R2 tick count", rd_data[3:0], 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule